// File: doc/BRIEF.md
# Dual-Channel Panel Pixel Formatter

This block sits between a pixel pipeline and a two-channel flat-panel link transmitter. Each cycle it may accept one 30-bit pixel (three 10-bit colours, red in the top field and blue in the bottom) together with a flag telling whether the pixel sits in an odd or an even position. It then prepares the pixel for the link. A two-bit depth field reduces each colour to 10, 8 or 6 significant bits. An optional 2x2 ordered dither can be added before the reduction. Colour components can be exchanged, with separate controls for odd and even pixels. The result is steered to one of two registered channel outputs.

With dual-channel operation enabled, odd-position pixels go to the odd channel and even-position pixels go to the even channel. A port-exchange bit reverses that mapping. The component swaps are chosen by the pixel's own parity before the exchange, so they follow the pixel and not the physical channel. With dual-channel operation disabled, all traffic uses the odd channel. Serialisation, electrical signalling and clock generation belong to other blocks.

Top module: `panel_pixel_formatter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both channel valids and both channel pixel buses are cleared to zero.
- R2: An accepted pixel (`in_valid` high) appears on exactly one channel output, with its valid high, one clock cycle later.
- R3: `cfg_depth` code 2'b10 keeps the top 8 bits of each colour and zeroes the low 2 bits. Code 2'b01 keeps the top 6 bits and zeroes the low 4 bits. Codes 2'b00 and 2'b11 pass all 10 bits unchanged.
- R4: When `cfg_dither` is high in a reduced mode, a threshold is added to each colour before truncation. The threshold is m shifted left by (dropped bits - 2), where m is chosen by {`in_frame_par`,`in_col_par`}: 00 gives 0, 01 gives 2, 10 gives 3, 11 gives 1.
- R5: The dithered sum saturates at 1023 before truncation.
- R6: In full-depth modes, `cfg_dither` has no effect on the output.
- R7: In `cfg_ctrl`, bit 3 swaps red and green and bit 2 swaps green and blue for odd-position pixels (`in_odd`=1). Bit 5 swaps red and green and bit 4 swaps green and blue for even-position pixels. The other bits are ignored.
- R8: When both swaps are enabled for a pixel, the red/green swap is applied first. Input (R,G,B) becomes (G,B,R).
- R9: With `cfg_dual` high and `cfg_port_swap` low, odd-position pixels go to the odd channel and even-position pixels go to the even channel.
- R10: With `cfg_dual` and `cfg_port_swap` both high, the channel mapping is exchanged. The swaps still follow the pixel's own parity.
- R11: With `cfg_dual` low, every pixel goes to the odd channel regardless of `cfg_port_swap`. The even channel keeps its last pixel with its valid low.
- R12: In a cycle without `in_valid`, both valids fall on the next edge and both pixel buses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_odd | input | 1 | 1 = odd-position pixel, 0 = even |
| in_col_par | input | 1 | Column parity used by the dither |
| in_frame_par | input | 1 | Frame parity used by the dither |
| in_pix | input | 30 | Pixel {R[29:20], G[19:10], B[9:0]} |
| cfg_depth | input | 2 | Output colour depth code |
| cfg_ctrl | input | 8 | Component swap control byte |
| cfg_dual | input | 1 | Two-channel operation enable |
| cfg_port_swap | input | 1 | Exchange odd/even channel mapping |
| cfg_dither | input | 1 | Ordered dither enable |
| odd_valid | output | 1 | Odd channel valid |
| odd_pix | output | 30 | Odd channel pixel |
| even_valid | output | 1 | Even channel valid |
| even_pix | output | 30 | Even channel pixel |

## Verification
The colour values are chosen so that each one tells a different effect apart. Values with ones only below the cut point show truncation. Values one threshold step short of the next kept level show the dither adding. Values near full scale show saturation. Distinct small values in R, G and B show every swap and the ordering of combined swaps. Each swap bit is tried with pixels of both parities, and with and without the port exchange, so that a swap tied to the channel instead of the pixel parity gets caught. Single-channel runs, idle cycles and a reset late in the run then confirm the held values on the unused channel.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

  typedef enum logic [1:0] {
    DEPTH_FULL     = 2'b00,
    DEPTH_LOW      = 2'b01,
    DEPTH_MID      = 2'b10,
    DEPTH_FULL_ALT = 2'b11
  } depth_e;

  // Swap control bit positions in the control byte
  localparam int SW_ODD_GB  = 2;
  localparam int SW_ODD_RG  = 3;
  localparam int SW_EVEN_GB = 4;
  localparam int SW_EVEN_RG = 5;

  // 2x2 ordered threshold, indexed by {frame parity, column parity}
  function automatic logic [1:0] dither_level(input logic frame_par, input logic col_par);
    logic [1:0] lvl;
    case ({frame_par, col_par})
      2'b00:   lvl = 2'd0;
      2'b01:   lvl = 2'd2;
      2'b10:   lvl = 2'd3;
      default: lvl = 2'd1;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/pfmt_depth.sv
// One colour: optional dither, saturation, truncation (R3-R6)
module pfmt_depth #(
  parameter int CW    = 10,
  parameter int MID_W = 8,
  parameter int LOW_W = 6
) (
  input  logic [CW-1:0]     c_in,
  input  pfmt_pkg::depth_e  mode,
  input  logic              dith_en,
  input  logic [1:0]        level,
  output logic [CW-1:0]     c_out
);
  localparam int DROP_MID = CW - MID_W;
  localparam int DROP_LOW = CW - LOW_W;

  logic [CW-1:0] thr;
  logic [CW-1:0] keep_mask;
  logic [CW:0]   sum;
  logic [CW-1:0] sat;

  always_comb begin
    thr       = '0;
    keep_mask = '1;
    case (mode)
      pfmt_pkg::DEPTH_MID: begin
        keep_mask = {CW{1'b1}} << DROP_MID;
        thr       = CW'(level) << (DROP_MID - 2);
      end
      pfmt_pkg::DEPTH_LOW: begin
        keep_mask = {CW{1'b1}} << DROP_LOW;
        thr       = CW'(level) << (DROP_LOW - 2);
      end
      default: begin
        keep_mask = '1;
        thr       = '0;
      end
    endcase
    sum   = {1'b0, c_in} + {1'b0, (dith_en ? thr : {CW{1'b0}})};
    sat   = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    c_out = sat & keep_mask;
  end
endmodule

// File: rtl/pfmt_swap.sv
// Component exchange: red/green first, then green/blue (R7, R8)
module pfmt_swap #(
  parameter int CW = 10
) (
  input  logic [3*CW-1:0] d,
  input  logic            rg_en,
  input  logic            gb_en,
  output logic [3*CW-1:0] q
);
  logic [CW-1:0] r0, g0, b0, r1, g1, g2, b2;

  always_comb begin
    r0 = d[3*CW-1:2*CW];
    g0 = d[2*CW-1:CW];
    b0 = d[CW-1:0];
    r1 = rg_en ? g0 : r0;
    g1 = rg_en ? r0 : g0;
    g2 = gb_en ? b0 : g1;
    b2 = gb_en ? g1 : b0;
    q  = {r1, g2, b2};
  end
endmodule

// File: rtl/pfmt_router.sv
// Registered two-channel output stage (R1, R2, R11, R12)
module pfmt_router #(
  parameter int PW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          to_even,
  input  logic [PW-1:0] pix,
  output logic          odd_valid,
  output logic [PW-1:0] odd_pix,
  output logic          even_valid,
  output logic [PW-1:0] even_pix
);
  always_ff @(posedge clk) begin
    if (rst) begin
      odd_valid  <= 1'b0;
      even_valid <= 1'b0;
      odd_pix    <= '0;
      even_pix   <= '0;
    end else begin
      odd_valid  <= valid & ~to_even;
      even_valid <= valid & to_even;
      if (valid & ~to_even) odd_pix  <= pix;
      if (valid & to_even)  even_pix <= pix;
    end
  end
endmodule

// File: rtl/panel_pixel_formatter.sv
module panel_pixel_formatter #(
  parameter int CW    = 10,
  parameter int MID_W = 8,
  parameter int LOW_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_odd,
  input  logic            in_col_par,
  input  logic            in_frame_par,
  input  logic [3*CW-1:0] in_pix,
  input  logic [1:0]      cfg_depth,
  input  logic [7:0]      cfg_ctrl,
  input  logic            cfg_dual,
  input  logic            cfg_port_swap,
  input  logic            cfg_dither,
  output logic            odd_valid,
  output logic [3*CW-1:0] odd_pix,
  output logic            even_valid,
  output logic [3*CW-1:0] even_pix
);
  localparam int NCOL = 3;
  localparam int PW   = NCOL * CW;

  logic [1:0]    level;
  logic [PW-1:0] reduced;
  logic [PW-1:0] swapped;
  logic          rg_sel, gb_sel, to_even;

  assign level = pfmt_pkg::dither_level(in_frame_par, in_col_par);

  genvar gi;
  generate
    for (gi = 0; gi < NCOL; gi++) begin : g_col
      pfmt_depth #(.CW(CW), .MID_W(MID_W), .LOW_W(LOW_W)) u_depth (
        .c_in    (in_pix[gi*CW +: CW]),
        .mode    (pfmt_pkg::depth_e'(cfg_depth)),
        .dith_en (cfg_dither),
        .level   (level),
        .c_out   (reduced[gi*CW +: CW])
      );
    end
  endgenerate

  // Swaps follow the pixel's own parity (R7), before the port exchange (R10)
  assign rg_sel = in_odd ? cfg_ctrl[pfmt_pkg::SW_ODD_RG] : cfg_ctrl[pfmt_pkg::SW_EVEN_RG];
  assign gb_sel = in_odd ? cfg_ctrl[pfmt_pkg::SW_ODD_GB] : cfg_ctrl[pfmt_pkg::SW_EVEN_GB];

  pfmt_swap #(.CW(CW)) u_swap (
    .d     (reduced),
    .rg_en (rg_sel),
    .gb_en (gb_sel),
    .q     (swapped)
  );

  // Destination: even channel only in dual mode (R9, R10, R11)
  assign to_even = cfg_dual & (~in_odd ^ cfg_port_swap);

  pfmt_router #(.PW(PW)) u_router (
    .clk        (clk),
    .rst        (rst),
    .valid      (in_valid),
    .to_even    (to_even),
    .pix        (swapped),
    .odd_valid  (odd_valid),
    .odd_pix    (odd_pix),
    .even_valid (even_valid),
    .even_pix   (even_pix)
  );
endmodule

// File: rtl/pfmt_checker.sv
module pfmt_checker #(
  parameter int CW    = 10,
  parameter int MID_W = 8,
  parameter int LOW_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_odd,
  input logic [1:0]      cfg_depth,
  input logic            cfg_dual,
  input logic            cfg_port_swap,
  input logic            odd_valid,
  input logic [3*CW-1:0] odd_pix,
  input logic            even_valid,
  input logic [3*CW-1:0] even_pix
);
  localparam logic [CW-1:0] LOSS_MID = CW'((1 << (CW - MID_W)) - 1);
  localparam logic [CW-1:0] LOSS_LOW = CW'((1 << (CW - LOW_W)) - 1);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_one_channel_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (odd_valid ^ even_valid));

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({odd_valid, even_valid}));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!odd_valid && !even_valid));

  assert_single_route_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_dual) |=> (odd_valid && !even_valid));

  assert_even_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && !even_valid) |-> $stable(even_pix));

  assert_dual_map_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_dual && !cfg_port_swap && in_odd) |=> odd_valid);

  assert_mid_depth_R3: assert property (@(posedge clk) disable iff (rst)
    (odd_valid && $past(cfg_depth) == 2'b10) |->
      ((odd_pix & {3{LOSS_MID}}) == '0));

  assert_low_depth_R3: assert property (@(posedge clk) disable iff (rst)
    (odd_valid && $past(cfg_depth) == 2'b01) |->
      ((odd_pix & {3{LOSS_LOW}}) == '0));
endmodule

bind panel_pixel_formatter pfmt_checker #(.CW(CW), .MID_W(MID_W), .LOW_W(LOW_W)) u_pfmt_checker (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_odd        (in_odd),
  .cfg_depth     (cfg_depth),
  .cfg_dual      (cfg_dual),
  .cfg_port_swap (cfg_port_swap),
  .odd_valid     (odd_valid),
  .odd_pix       (odd_pix),
  .even_valid    (even_valid),
  .even_pix      (even_pix)
);

// File: tb/test_panel_pixel_formatter.sv
`timescale 1ns/1ps
module test_panel_pixel_formatter;
  localparam int CW = 10;
  localparam int PW = 3 * CW;
  localparam int NV = 18;
  localparam int VW = 24 + 1 + 1 + 1 + 2 + 8 + 1 + 1 + 1 + PW + 1 + 1 + PW;

  // {tag, odd, col, frame, depth, ctrl, dual, pswap, dither, pix, exp_ov, exp_ev, exp}
  localparam logic [VW-1:0] VEC [NV] = '{
    {"R9 ", 1'b1,1'b0,1'b0,2'b00,8'h00,1'b1,1'b0,1'b0, 10'd100,10'd200,10'd300, 1'b1,1'b0, 10'd100,10'd200,10'd300},
    {"R9 ", 1'b0,1'b0,1'b0,2'b00,8'h00,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b0,1'b1, 10'd1,10'd2,10'd3},
    {"R3 ", 1'b1,1'b0,1'b0,2'b11,8'h00,1'b1,1'b0,1'b0, 10'd1023,10'd5,10'd6,    1'b1,1'b0, 10'd1023,10'd5,10'd6},
    {"R3 ", 1'b1,1'b0,1'b0,2'b10,8'h00,1'b1,1'b0,1'b0, 10'd7,10'd1022,10'd513,  1'b1,1'b0, 10'd4,10'd1020,10'd512},
    {"R3 ", 1'b0,1'b0,1'b0,2'b01,8'h00,1'b1,1'b0,1'b0, 10'd31,10'd1023,10'd15,  1'b0,1'b1, 10'd16,10'd1008,10'd0},
    {"R5 ", 1'b1,1'b1,1'b0,2'b10,8'h00,1'b1,1'b0,1'b1, 10'd2,10'd1,10'd1022,    1'b1,1'b0, 10'd4,10'd0,10'd1020},
    {"R4 ", 1'b1,1'b0,1'b1,2'b01,8'h00,1'b1,1'b0,1'b1, 10'd4,10'd3,10'd1020,    1'b1,1'b0, 10'd16,10'd0,10'd1008},
    {"R6 ", 1'b1,1'b1,1'b1,2'b00,8'h00,1'b1,1'b0,1'b1, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd1,10'd2,10'd3},
    {"R7 ", 1'b1,1'b0,1'b0,2'b00,8'h08,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd2,10'd1,10'd3},
    {"R7 ", 1'b0,1'b0,1'b0,2'b00,8'h08,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b0,1'b1, 10'd1,10'd2,10'd3},
    {"R7 ", 1'b1,1'b0,1'b0,2'b00,8'h04,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd1,10'd3,10'd2},
    {"R7 ", 1'b0,1'b0,1'b0,2'b00,8'h20,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b0,1'b1, 10'd2,10'd1,10'd3},
    {"R7 ", 1'b0,1'b0,1'b0,2'b00,8'hD0,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b0,1'b1, 10'd1,10'd3,10'd2},
    {"R8 ", 1'b1,1'b0,1'b0,2'b00,8'h0C,1'b1,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd2,10'd3,10'd1},
    {"R10", 1'b1,1'b0,1'b0,2'b00,8'h08,1'b1,1'b1,1'b0, 10'd1,10'd2,10'd3,       1'b0,1'b1, 10'd2,10'd1,10'd3},
    {"R10", 1'b0,1'b0,1'b0,2'b00,8'h20,1'b1,1'b1,1'b0, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd2,10'd1,10'd3},
    {"R11", 1'b0,1'b0,1'b0,2'b00,8'h00,1'b0,1'b0,1'b0, 10'd1,10'd2,10'd3,       1'b1,1'b0, 10'd1,10'd2,10'd3},
    {"R11", 1'b1,1'b0,1'b0,2'b00,8'h00,1'b0,1'b1,1'b0, 10'd4,10'd5,10'd6,       1'b1,1'b0, 10'd4,10'd5,10'd6}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_odd = 1'b0, in_col_par = 1'b0, in_frame_par = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic [1:0]    cfg_depth = 2'b00;
  logic [7:0]    cfg_ctrl = 8'h00;
  logic          cfg_dual = 1'b1, cfg_port_swap = 1'b0, cfg_dither = 1'b0;
  logic          odd_valid, even_valid;
  logic [PW-1:0] odd_pix, even_pix;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  panel_pixel_formatter i_panel_pixel_formatter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_odd(in_odd),
    .in_col_par(in_col_par), .in_frame_par(in_frame_par), .in_pix(in_pix),
    .cfg_depth(cfg_depth), .cfg_ctrl(cfg_ctrl), .cfg_dual(cfg_dual),
    .cfg_port_swap(cfg_port_swap), .cfg_dither(cfg_dither),
    .odd_valid(odd_valid), .odd_pix(odd_pix),
    .even_valid(even_valid), .even_pix(even_pix)
  );

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [PW-1:0] last_even;
    logic [PW-1:0] last_odd;
    last_even = '0;
    last_odd  = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {odd_valid, even_valid}, '0);
    check("R1", odd_pix, '0);
    check("R1", even_pix, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tg;
      v = VEC[i];
      tg = string'(v[VW-1 -: 24]);
      in_valid      = 1'b1;
      in_odd        = v[VW-25];
      in_col_par    = v[VW-26];
      in_frame_par  = v[VW-27];
      cfg_depth     = v[VW-28 -: 2];
      cfg_ctrl      = v[VW-30 -: 8];
      cfg_dual      = v[VW-38];
      cfg_port_swap = v[VW-39];
      cfg_dither    = v[VW-40];
      in_pix        = v[2*PW+1 -: PW];
      @(posedge clk);
      #1;
      check(tg, {odd_valid, even_valid}, PW'({v[PW+1], v[PW]}));
      if (v[PW+1]) begin
        check(tg, odd_pix, v[PW-1:0]);
        last_odd = v[PW-1:0];
      end
      if (v[PW]) begin
        check(tg, even_pix, v[PW-1:0]);
        last_even = v[PW-1:0];
      end
    end

    // R11: even channel kept its last pixel through single-channel traffic
    check("R11", even_pix, last_even);

    // R12: idle cycle, valids drop, data held
    in_valid = 1'b0;
    in_pix   = {10'd77, 10'd88, 10'd99};
    @(posedge clk);
    #1;
    check("R12", {odd_valid, even_valid}, '0);
    check("R12", odd_pix, last_odd);
    check("R12", even_pix, last_even);

    // R6: dither with depth code 2'b11 leaves values alone (full scale, no wrap)
    in_valid = 1'b1; in_odd = 1'b1; cfg_dual = 1'b1; cfg_port_swap = 1'b0;
    cfg_ctrl = 8'h00; cfg_depth = 2'b11; cfg_dither = 1'b1;
    in_col_par = 1'b0; in_frame_par = 1'b1;
    in_pix = {10'd1023, 10'd1021, 10'd9};
    @(posedge clk);
    #1;
    check("R6", odd_pix, {10'd1023, 10'd1021, 10'd9});

    // R4: column odd, frame odd -> m=1, 8-bit: 3+1=4
    cfg_depth = 2'b10; in_col_par = 1'b1; in_frame_par = 1'b1;
    in_pix = {10'd3, 10'd2, 10'd1020};
    @(posedge clk);
    #1;
    check("R4", odd_pix, {10'd4, 10'd0, 10'd1020});

    // R1: reset late in the run clears both channels
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {odd_valid, even_valid}, '0);
    check("R1", odd_pix, '0);
    check("R1", even_pix, '0);
    rst = 1'b0;
    in_valid = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule